// File: doc/BRIEF.md
# Interrupt Skip Filter

This block sits between timer event sources and the interrupt controller and thins out repeated interrupt requests. Each source carries a small skip count N. When N is zero every event goes through. When N is non-zero the first event goes through, the next N events are swallowed, and the pattern then repeats, so one request in every N+1 reaches the output.

Sources come in groups. Each group has three sources: a counter-overflow event, a compare-A event and an A/D-trigger request event. A per-group mode bit decides which sources are thinned. Function 1 (mode 0) thins the overflow and compare-A sources. Function 2 (mode 1) thins only the A/D-trigger source. A source that the current mode does not select is forwarded unchanged.

Configuration uses a write-only port. The address high bits pick the group and the two low bits pick the field: 0 is the mode bit (data bit 0), 1 is the overflow skip count, 2 is the compare-A skip count and 3 is the A/D-trigger skip count. Source index s in `ev_in`/`irq_out` is group*3 + kind, where kind 0 is overflow, 1 is compare-A and 2 is A/D-trigger.

Top module: `irq_skip_ctl`

## Requirements
- R1: After reset every skip count is 0, every mode bit is 0 (function 1) and every counter is 0, so every event is forwarded.
- R2: A source whose skip count is 0 forwards every event in the cycle it arrives.
- R3: A selected source with skip count N in 1..7 forwards one event, suppresses the next N events, then forwards again, with period N+1. Cycles without an event do not advance the pattern.
- R4: Mode 0 thins the overflow (kind 0) and compare-A (kind 1) sources and forwards the A/D-trigger (kind 2) source unchanged. Mode 1 does the reverse.
- R5: The groups are independent. The mode and counts of one group have no effect on the other group's outputs.
- R6: Writing a skip count (field 1, 2 or 3) clears that source's counter, so its next event is forwarded.
- R7: Writing a group's mode bit (field 0) clears all three counters of that group.
- R8: `irq_out[s]` is high only in a cycle where `ev_in[s]` is high. Outputs are combinational single-cycle pulses.
- R9: If an event and a configuration write to the same source arrive in the same cycle, the event is judged on the state before the write, and the counter ends at 0.
- R10: Each source keeps its own count and counter. Thinning one source does not change the pattern of any other source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (3) | {group, field} write address |
| cfg_wdata | input | CNT_W (3) | Skip count, or mode in bit 0 |
| ev_in | input | 3*GROUPS (6) | Single-cycle event pulses per source |
| irq_out | output | 3*GROUPS (6) | Forwarded interrupt pulses per source |

## Verification
The bench drives one mode per group at once. The same burst of events then shows a skip-by-2, a skip-by-1, a zero count and unselected sources side by side:
- A counter that wraps one step early or late would break the period-of-N+1 pattern.
- A mode decode that is inverted would thin the wrong kind of source.

The bench also checks that a counter is cleared by a count write and by a mode write. If either write failed to clear it, the next event would be swallowed.

Finally, the bench writes and raises an event in the same cycle. A design that let the write bypass the old state would forward an event that should be suppressed.

// File: rtl/irq_skip_ctl.sv
module irq_skip_ctl #(
  parameter int GROUPS = 2,
  parameter int CNT_W  = 3,
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int ADDR_W = GW + 2,
  localparam int NSRC   = 3 * GROUPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  input  logic [NSRC-1:0]   ev_in,
  output logic [NSRC-1:0]   irq_out
);

  logic [GROUPS-1:0]     mode_q;
  logic [NSRC*CNT_W-1:0] skip_q;
  logic [NSRC*CNT_W-1:0] cnt_q;

  wire [GW-1:0] wr_grp = cfg_addr[ADDR_W-1:2];
  wire [1:0]    wr_fld = cfg_addr[1:0];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) mode_q[g] <= 1'b0;
      else if (cfg_we && wr_grp == GW'(g) && wr_fld == 2'd0) mode_q[g] <= cfg_wdata[0];
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int G = s / 3;
    localparam int K = s % 3;

    wire [CNT_W-1:0] skip = skip_q[s*CNT_W +: CNT_W];
    wire [CNT_W-1:0] cnt  = cnt_q[s*CNT_W +: CNT_W];
    wire hit_grp  = cfg_we && (wr_grp == GW'(G));
    wire wr_skip  = hit_grp && (wr_fld == 2'(K + 1));
    wire wr_mode  = hit_grp && (wr_fld == 2'd0);
    wire active   = (K == 2) ? mode_q[G] : !mode_q[G];
    wire thinning = active && (skip != '0);

    assign irq_out[s] = ev_in[s] && !(thinning && cnt != '0);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) skip_q[s*CNT_W +: CNT_W] <= '0;
      else if (wr_skip) skip_q[s*CNT_W +: CNT_W] <= cfg_wdata;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cnt_q[s*CNT_W +: CNT_W] <= '0;
      else if (wr_skip || wr_mode) cnt_q[s*CNT_W +: CNT_W] <= '0;
      else if (ev_in[s] && thinning)
        cnt_q[s*CNT_W +: CNT_W] <= (cnt == skip) ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/irq_skip_ctl_chk.sv
module irq_skip_ctl_chk #(
  parameter int GROUPS = 2,
  parameter int CNT_W  = 3,
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int ADDR_W = GW + 2,
  localparam int NSRC   = 3 * GROUPS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [NSRC-1:0]   ev_in,
  input logic [NSRC-1:0]   irq_out,
  input logic [GROUPS-1:0] mode_q,
  input logic [NSRC*CNT_W-1:0] skip_q,
  input logic [NSRC*CNT_W-1:0] cnt_q
);

  // R8
  out_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~ev_in) == '0);

  for (genvar s = 0; s < NSRC; s++) begin : g_s
    localparam int G = s / 3;
    localparam int K = s % 3;
    wire [CNT_W-1:0] cnt  = cnt_q[s*CNT_W +: CNT_W];
    wire [CNT_W-1:0] skip = skip_q[s*CNT_W +: CNT_W];
    wire sel = (K == 2) ? mode_q[G] : !mode_q[G];
    wire grp_hit = cfg_we && cfg_addr[ADDR_W-1:2] == GW'(G);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= skip);
    // R3
    pass_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_in[s] && irq_out[s] && sel && skip != '0 && !cfg_we) |=> cnt == CNT_W'(1));
    // R2
    zero_skip_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (skip == '0) |-> irq_out[s] == ev_in[s]);
    // R4
    unselected_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> irq_out[s] == ev_in[s]);
    // R6
    skip_wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_hit && cfg_addr[1:0] == 2'(K + 1)) |=> cnt == '0);
    // R7
    mode_wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_hit && cfg_addr[1:0] == 2'd0) |=> cnt == '0);
  end

endmodule

bind irq_skip_ctl irq_skip_ctl_chk #(.GROUPS(GROUPS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .ev_in(ev_in), .irq_out(irq_out), .mode_q(mode_q), .skip_q(skip_q), .cnt_q(cnt_q)
);

// File: tb/irq_skip_ctl_test.sv
`timescale 1ns/1ps
module irq_skip_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [2:0] cfg_wdata = '0;
  logic [5:0] ev_in = '0;
  logic [5:0] irq_out;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  irq_skip_ctl uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
                    .cfg_wdata(cfg_wdata), .ev_in(ev_in), .irq_out(irq_out));

  // {ev_in, expected irq_out}; A: mode0 ovf=2 cmp=0 trg=3; B: mode1 ovf=5 cmp=7 trg=1
  localparam logic [11:0] VEC [10] = '{
    {6'b111111, 6'b111111}, {6'b111111, 6'b011110}, {6'b111111, 6'b111110},
    {6'b111111, 6'b011111}, {6'b111111, 6'b111110}, {6'b111111, 6'b011110},
    {6'b000000, 6'b000000}, {6'b000001, 6'b000001}, {6'b100000, 6'b100000},
    {6'b100001, 6'b000000}};

  task automatic check(input logic [5:0] exp, input string req);
    total++;
    if (irq_out !== exp) begin
      bad++;
      $display("FAIL %s: irq_out=%b expected=%b", req, irq_out, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [2:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic step(input logic [5:0] ev, input logic [5:0] exp, input string req);
    @(negedge clk); ev_in = ev;
    #2 check(exp, req);
    @(posedge clk); #1 ev_in = '0;
  endtask

  initial begin
    #20000;
    bad++; total++;
    $display("FAIL watchdog: expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(6'b111111, 6'b111111, "R1");
    step(6'b111111, 6'b111111, "R1 R2");
    wr(3'b001, 3'd2); wr(3'b010, 3'd0); wr(3'b011, 3'd3);
    wr(3'b100, 3'd1); wr(3'b101, 3'd5); wr(3'b110, 3'd7); wr(3'b111, 3'd1);
    // R3 R4 R5 R10 R2 R8 vectors
    for (int i = 0; i < 10; i++) step(VEC[i][11:6], VEC[i][5:0], "R3/R4/R5/R10 vector");
    step(6'b000000, 6'b000000, "R8");
    // src0 counter now 2; rewrite its count
    wr(3'b001, 3'd2);
    step(6'b000001, 6'b000001, "R6");
    // src0 counter now 1; rewrite group A mode with same value
    wr(3'b000, 3'd0);
    step(6'b000001, 6'b000001, "R7");
    // switch group A to function 2: ovf unthinned, trg thinned (skip 3)
    wr(3'b000, 3'd1);
    step(6'b000001, 6'b000001, "R4 ovf unselected");
    step(6'b000001, 6'b000001, "R4 ovf unselected");
    step(6'b000100, 6'b000100, "R4 trg first");
    step(6'b000100, 6'b000000, "R3 trg skip");
    step(6'b000100, 6'b000000, "R3 trg skip");
    step(6'b000100, 6'b000000, "R3 trg skip");
    step(6'b000100, 6'b000100, "R3 trg repeat");
    // group B trg (skip 1): counter 0 now
    step(6'b100000, 6'b100000, "R5 B trg pass");
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'b111; cfg_wdata = 3'd1; ev_in = 6'b100000;
    #2 check(6'b000000, "R9 old state");
    @(posedge clk); #1 cfg_we = 1'b0; ev_in = '0;
    step(6'b100000, 6'b100000, "R9 counter cleared");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule